// File: doc/BRIEF.md
# Word-Organised Fuse Reader with Byte Extraction

This block reads a one-time-programmable fuse array that can only be accessed one 32-bit word at a time. A request names any byte offset and any byte length. The reader works out which aligned words cover that byte range and reads each of them with a timed pin sequence. It then streams out only the requested bytes, one per cycle, in ascending address order.

The fuse macro is driven directly from registered pins:

- chip-select (active low) and power-down;
- program-enable, load, strobe, strobe-shift-select and sense enable;
- a 10-bit word address.

Every phase of the sequence is held for a settle interval. Its length is set by the `SETTLE_CYCLES` parameter: about 1 µs of clock cycles, which is 50 cycles at 50 MHz.

Bytes are sent out as soon as each word has been sampled, so the block never holds more than one word. Bytes that lie before the offset in the first word, or after the end in the last word, are dropped and take no cycles on the stream. When the last word has been read, the macro returns to standby. The block ignores requests while it is busy and flags them as rejected.

Top module: `fuse_word_reader`

## Requirements
- R1: The number of word reads is ceil((offset+length)/4) − floor(offset/4). For a zero length there are none. The first word address is floor(offset/4) modulo 1024, and each later read uses the previous address plus one, modulo 1024.
- R2: Exactly `length` bytes come out on `out_byte` while `out_valid` is high, in the order of byte addresses offset .. offset+length−1. Byte k (0..3) of a fuse word is taken from bits 8k+7:8k, so the least significant byte comes first.
- R3: Before the first strobe of a request, load, program-enable, strobe-shift-select and sense enable are high, and chip-select and power-down are low, for at least SETTLE_CYCLES cycles. This read mode holds whenever strobe is high.
- R4: Strobe and the word address change on the same clock edge. Strobe then stays high for exactly SETTLE_CYCLES cycles with the address stable, and the data word is sampled on the last of those cycles.
- R5: Between two strobe pulses of one request, strobe stays low for at least SETTLE_CYCLES cycles.
- R6: After reset and whenever the block is idle, chip-select and power-down are high and all other fuse controls are low. After the last word, the pins return to this standby state.
- R7: A zero-length request raises `done` in the cycle after it is accepted. It produces no strobe and no bytes.
- R8: `busy` is high from the cycle after a request is accepted until the cycle after `done`. A `req_valid` seen while busy raises `req_reject` in that same cycle and has no effect on the strobes or the byte stream of the running request. No byte is sent while the block is idle.
- R9: `done` is a one-cycle pulse that comes after the last byte of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_offset | input | ADDR_W+2 | Byte offset of the first requested byte |
| req_len | input | LEN_W | Number of bytes requested |
| busy | output | 1 | A request is in progress |
| req_reject | output | 1 | Request seen while busy and ignored |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | `out_byte` carries a requested byte |
| out_byte | output | 8 | Extracted byte |
| fz_csb | output | 1 | Fuse chip-select, active low |
| fz_pgenb | output | 1 | Fuse program-enable control |
| fz_load | output | 1 | Fuse load control |
| fz_strobe | output | 1 | Fuse read strobe |
| fz_strb_sel | output | 1 | Fuse strobe-shift-select |
| fz_sense_en | output | 1 | Fuse read-sense enable |
| fz_pd | output | 1 | Fuse power-down |
| fz_addr | output | ADDR_W | Fuse word address |
| fz_dout | input | 32 | Fuse word data |

## Verification
A wrong byte index or a wrong remaining count shows at the ports within the first word. It appears as a wrong byte value, or as a stream that is too short or too long by the time `done` pulses. A wrong word address shows on `fz_addr` at the rising edge of strobe, and its data appears a few cycles later on the stream. Timer or sequencer faults show up as strobe pulses or gaps of the wrong length, or as the pins leaving standby without a request. These faults are visible on the first pulse that is affected. Sweeping every offset within the first words against every short length covers all the ways a request can start and end inside a word.

// File: rtl/fwr_pkg.sv
// Shared types for the fuse word reader: sequencer states and the fuse pin bundle.
package fwr_pkg;
    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 8 * WORD_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_STROBE,
        ST_EMIT,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic csb;
        logic pgenb;
        logic load;
        logic strobe;
        logic strb_sel;
        logic sense_en;
        logic pd;
    } fuse_ctl_t;

    localparam fuse_ctl_t CTL_STANDBY = '{csb: 1'b1, pgenb: 1'b0, load: 1'b0, strobe: 1'b0,
                                          strb_sel: 1'b0, sense_en: 1'b0, pd: 1'b1};
    localparam fuse_ctl_t CTL_READ    = '{csb: 1'b0, pgenb: 1'b1, load: 1'b1, strobe: 1'b0,
                                          strb_sel: 1'b1, sense_en: 1'b1, pd: 1'b0};
endpackage

// File: rtl/fwr_settle_timer.sv
// Settle interval counter.
// Assumes: start is pulsed on the edge that enters a timed phase; expired is
// then high in the last of SETTLE_CYCLES cycles of that phase. SETTLE_CYCLES >= 1.
module fwr_settle_timer #(
    parameter int SETTLE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fwr_byte_lane.sv
// Word address, captured word and byte bookkeeping.
// Holds the current word address, the sampled fuse word, the byte index inside
// that word and the number of bytes still owed. Assumes load_req, capture,
// emit and advance are never high together.
module fwr_byte_lane #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_req,
    input  logic [ADDR_W+1:0]           req_offset,
    input  logic [LEN_W-1:0]            req_len,
    input  logic                        capture,
    input  logic [fwr_pkg::DATA_W-1:0]  fz_dout,
    input  logic                        emit,
    input  logic                        advance,
    output logic [ADDR_W-1:0]           waddr,
    output logic [7:0]                  out_byte,
    output logic                        word_end,
    output logic                        rem_zero
);
    localparam int BSEL_W = $clog2(fwr_pkg::WORD_BYTES);
    localparam int OFF_W  = ADDR_W + BSEL_W;

    logic [ADDR_W-1:0]          waddr_q;
    logic [BSEL_W-1:0]          bidx_q;
    logic [LEN_W-1:0]           rem_q;
    logic [fwr_pkg::DATA_W-1:0] word_q;

    // Load the request, capture words, step byte index and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            bidx_q  <= '0;
            rem_q   <= '0;
            word_q  <= '0;
        end else begin
            if (load_req) begin
                waddr_q <= req_offset[OFF_W-1:BSEL_W];
                bidx_q  <= req_offset[BSEL_W-1:0];
                rem_q   <= req_len;
            end
            if (capture) begin
                word_q <= fz_dout;
            end
            if (emit) begin
                bidx_q <= bidx_q + 1'b1;
                rem_q  <= rem_q - 1'b1;
            end
            if (advance) begin
                waddr_q <= waddr_q + 1'b1;
            end
        end
    end

    // Select the current byte, least significant first.
    always_comb begin
        out_byte = word_q[8*bidx_q +: 8];
    end

    assign waddr    = waddr_q;
    assign word_end = (bidx_q == '1) || (rem_q == LEN_W'(1));
    assign rem_zero = (rem_q == '0);
endmodule

// File: rtl/fwr_sequencer.sv
// Read sequencer: read-mode entry, strobe, byte emission, gap, standby.
// Fuse pins come from a register loaded from the next-state decode, so they
// change together with the state and never glitch. Assumes the timer reports
// expiry in the last cycle of each timed phase.
module fwr_sequencer (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_len_zero,
    input  logic               tmr_expired,
    input  logic               word_end,
    input  logic               rem_zero,
    output logic               busy,
    output logic               done,
    output logic               tmr_start,
    output logic               load_req,
    output logic               capture,
    output logic               emit,
    output logic               advance,
    output fwr_pkg::fuse_ctl_t ctl
);
    import fwr_pkg::*;

    seq_state_t state_q, state_d;
    fuse_ctl_t  ctl_q, ctl_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        load_req  = 1'b0;
        capture   = 1'b0;
        emit      = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load_req = 1'b1;
                    if (req_len_zero) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d   = ST_ENTER;
                        tmr_start = 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                if (tmr_expired) begin
                    state_d   = ST_STROBE;
                    tmr_start = 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                emit = 1'b1;
                if (word_end) begin
                    state_d   = ST_GAP;
                    tmr_start = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    if (rem_zero) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d   = ST_STROBE;
                        tmr_start = 1'b1;
                        advance   = 1'b1;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin pattern for the state being entered.
    always_comb begin
        unique case (state_d)
            ST_IDLE, ST_DONE: ctl_d = CTL_STANDBY;
            ST_STROBE: begin
                ctl_d        = CTL_READ;
                ctl_d.strobe = 1'b1;
            end
            default:          ctl_d = CTL_READ;
        endcase
    end

    // State and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_STANDBY;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);
    assign ctl  = ctl_q;
endmodule

// File: rtl/fuse_word_reader.sv
// Top level of the fuse word reader.
// Accepts a byte offset and length, reads the covering aligned 32-bit words
// from the fuse macro and streams out only the requested bytes. Assumes
// fz_dout is valid by the last cycle of each strobe pulse.
module fuse_word_reader #(
    parameter int ADDR_W        = 10,
    parameter int LEN_W         = 12,
    parameter int SETTLE_CYCLES = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W+1:0]          req_offset,
    input  logic [LEN_W-1:0]           req_len,
    output logic                       busy,
    output logic                       req_reject,
    output logic                       done,
    output logic                       out_valid,
    output logic [7:0]                 out_byte,
    output logic                       fz_csb,
    output logic                       fz_pgenb,
    output logic                       fz_load,
    output logic                       fz_strobe,
    output logic                       fz_strb_sel,
    output logic                       fz_sense_en,
    output logic                       fz_pd,
    output logic [ADDR_W-1:0]          fz_addr,
    input  logic [fwr_pkg::DATA_W-1:0] fz_dout
);
    fwr_pkg::fuse_ctl_t ctl;
    logic tmr_start, tmr_expired;
    logic load_req, capture, emit, advance;
    logic word_end, rem_zero;

    fwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    fwr_sequencer seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_len_zero (req_len == '0),
        .tmr_expired  (tmr_expired),
        .word_end     (word_end),
        .rem_zero     (rem_zero),
        .busy         (busy),
        .done         (done),
        .tmr_start    (tmr_start),
        .load_req     (load_req),
        .capture      (capture),
        .emit         (emit),
        .advance      (advance),
        .ctl          (ctl)
    );

    fwr_byte_lane #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) lane_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .req_offset (req_offset),
        .req_len    (req_len),
        .capture    (capture),
        .fz_dout    (fz_dout),
        .emit       (emit),
        .advance    (advance),
        .waddr      (fz_addr),
        .out_byte   (out_byte),
        .word_end   (word_end),
        .rem_zero   (rem_zero)
    );

    assign req_reject  = req_valid && busy;
    assign out_valid   = emit;
    assign fz_csb      = ctl.csb;
    assign fz_pgenb    = ctl.pgenb;
    assign fz_load     = ctl.load;
    assign fz_strobe   = ctl.strobe;
    assign fz_strb_sel = ctl.strb_sel;
    assign fz_sense_en = ctl.sense_en;
    assign fz_pd       = ctl.pd;
endmodule

// File: rtl/fwr_checker.sv
// Port-level protocol checker for fuse_word_reader, attached by bind.
module fwr_checker #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W+1:0] req_offset,
    input logic [LEN_W-1:0]  req_len,
    input logic              busy,
    input logic              done,
    input logic              out_valid,
    input logic              fz_csb,
    input logic              fz_pgenb,
    input logic              fz_load,
    input logic              fz_strobe,
    input logic              fz_strb_sel,
    input logic              fz_sense_en,
    input logic              fz_pd,
    input logic [ADDR_W-1:0] fz_addr
);
    logic              strobe_d, first_q;
    logic [ADDR_W-1:0] last_addr_q, first_word_q;
    logic [LEN_W-1:0]  cnt_q, len_q;
    logic              accept;

    assign accept = req_valid && !busy;

    // Track the request, bytes delivered and the last strobed address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d     <= 1'b0;
            first_q      <= 1'b0;
            last_addr_q  <= '0;
            first_word_q <= '0;
            cnt_q        <= '0;
            len_q        <= '0;
        end else begin
            strobe_d <= fz_strobe;
            if (accept) begin
                first_q      <= 1'b1;
                first_word_q <= req_offset[ADDR_W+1:2];
                cnt_q        <= '0;
                len_q        <= req_len;
            end else if (out_valid) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fz_strobe && !strobe_d) begin
                first_q     <= 1'b0;
                last_addr_q <= fz_addr;
            end
        end
    end

    AST_STANDBY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fz_csb && fz_pd && !fz_pgenb && !fz_load && !fz_strobe && !fz_strb_sel && !fz_sense_en)); // R6
    AST_READ_MODE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fz_strobe |-> (fz_load && fz_pgenb && fz_strb_sel && fz_sense_en && !fz_csb && !fz_pd)); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_strobe && $past(fz_strobe)) |-> $stable(fz_addr)); // R4
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fz_strobe) && first_q) |-> (fz_addr == first_word_q)); // R1
    AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fz_strobe) && !first_q) |-> (fz_addr == ADDR_W'(last_addr_q + 1'b1))); // R1
    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt_q < len_q)); // R2
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == len_q)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_NO_BYTES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid); // R8
endmodule

bind fuse_word_reader fwr_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_offset  (req_offset),
    .req_len     (req_len),
    .busy        (busy),
    .done        (done),
    .out_valid   (out_valid),
    .fz_csb      (fz_csb),
    .fz_pgenb    (fz_pgenb),
    .fz_load     (fz_load),
    .fz_strobe   (fz_strobe),
    .fz_strb_sel (fz_strb_sel),
    .fz_sense_en (fz_sense_en),
    .fz_pd       (fz_pd),
    .fz_addr     (fz_addr)
);

// File: tb/fuse_word_reader_tb_top.sv
module fuse_word_reader_tb_top;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 12;
    localparam int S      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W+1:0] req_offset = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic busy, req_reject, done, out_valid;
    logic [7:0] out_byte;
    logic fz_csb, fz_pgenb, fz_load, fz_strobe, fz_strb_sel, fz_sense_en, fz_pd;
    logic [ADDR_W-1:0] fz_addr;
    logic [31:0] fz_dout;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    // Monitor state
    int  nb, rises, setup_cnt, gap, hi_run, exp_addr;
    bit  had_fall, done_seen, prev_strobe;
    byte got [0:127];

    always #10 clk = ~clk;

    // Behavioural fuse array: distinct bytes per word, valid while strobe is high.
    function automatic logic [31:0] fword(input int w);
        return (32'h9E37_79B9 * (w + 1)) ^ (w << 12);
    endfunction
    function automatic logic [7:0] fbyte(input int a);
        logic [31:0] wv;
        wv = fword((a >> 2) & 1023);
        return wv[8*(a & 3) +: 8];
    endfunction

    assign fz_dout = fz_strobe ? fword(int'(fz_addr)) : 32'h0;

    fuse_word_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_len(req_len), .busy(busy), .req_reject(req_reject), .done(done),
        .out_valid(out_valid), .out_byte(out_byte), .fz_csb(fz_csb), .fz_pgenb(fz_pgenb),
        .fz_load(fz_load), .fz_strobe(fz_strobe), .fz_strb_sel(fz_strb_sel),
        .fz_sense_en(fz_sense_en), .fz_pd(fz_pd), .fz_addr(fz_addr), .fz_dout(fz_dout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit standby_ok();
        return fz_csb && fz_pd && !fz_pgenb && !fz_load && !fz_strobe && !fz_strb_sel && !fz_sense_en;
    endfunction
    function automatic bit readmode_ok();
        return fz_load && fz_pgenb && fz_strb_sel && fz_sense_en && !fz_csb && !fz_pd;
    endfunction

    // Pin and stream monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fz_strobe && !prev_strobe) begin
                chk(int'(fz_addr) == (exp_addr & 1023), "R1 strobe address", int'(fz_addr), exp_addr & 1023);
                chk(readmode_ok(), "R3 read mode at strobe", 0, 1);
                if (rises == 0) chk(setup_cnt >= S, "R3 read-mode setup", setup_cnt, S);
                else if (had_fall) chk(gap >= S, "R5 strobe gap", gap, S);
                exp_addr++;
                rises++;
                hi_run = 0;
            end
            if (!fz_strobe && prev_strobe) begin
                chk(hi_run == S, "R4 strobe width", hi_run, S);
                had_fall = 1;
                gap = 0;
            end
            if (fz_strobe) hi_run++;
            else gap++;
            if (rises == 0 && readmode_ok()) setup_cnt++;
            if (out_valid && nb < 128) begin
                got[nb] = out_byte;
                nb++;
            end
            if (done) done_seen = 1;
            prev_strobe = fz_strobe;
        end
    end

    task automatic run_req(input int off, input int len, input bit inject);
        int words, t;
        bit bytes_ok;
        int bad_i;
        words = (len == 0) ? 0 : ((off + len + 3) >> 2) - (off >> 2);
        nb = 0; rises = 0; setup_cnt = 0; gap = 0; hi_run = 0;
        had_fall = 0; done_seen = 0; exp_addr = off >> 2;
        req_offset = (ADDR_W+2)'(off);
        req_len    = LEN_W'(len);
        req_valid  = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (len == 0) begin
            chk(done == 1'b1, "R7 zero-length done next cycle", done, 1);
        end
        if (inject) begin
            req_offset = '0;
            req_len    = LEN_W'(3);
            req_valid  = 1'b1;
            #1;
            chk(req_reject == 1'b1, "R8 reject while busy", req_reject, 1);
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
        t = 0;
        while (!done_seen && t < 5000) begin
            @(negedge clk); #1;
            t++;
        end
        chk(done_seen, "R9 done reached", done_seen, 1);
        chk(nb == len, "R2 byte count", nb, len);
        chk(rises == words, "R1 word read count", rises, words);
        bytes_ok = 1; bad_i = 0;
        for (int i = 0; i < len && i < nb; i++) begin
            if (bytes_ok && got[i] != fbyte(off + i)) begin
                bytes_ok = 0;
                bad_i = i;
            end
        end
        chk(bytes_ok, "R2 byte values", bytes_ok ? 0 : int'(got[bad_i]),
            bytes_ok ? 0 : int'(fbyte(off + bad_i)));
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done single cycle", done, 0);
        chk(busy == 1'b0, "R8 busy clears", busy, 0);
        chk(standby_ok(), "R6 standby after request", 0, 1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        prev_strobe = 0;
        nb = 0; rises = 0; setup_cnt = 0; gap = 0; hi_run = 0; exp_addr = 0;
        had_fall = 0; done_seen = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(standby_ok(), "R6 reset standby", 0, 1);
        chk(busy == 1'b0, "R8 reset not busy", busy, 0);
        chk(out_valid == 1'b0, "R8 reset no output", out_valid, 0);
        chk(done == 1'b0, "R9 reset no done", done, 0);
        // Sweep of start positions and lengths (R1 R2 R7)
        for (int off = 0; off < 10; off++) begin
            for (int len = 0; len < 10; len++) begin
                run_req(off, len, 1'b0);
            end
        end
        run_req(4093, 5, 1'b0);   // address wraps past the last word (R1)
        run_req(3, 40, 1'b0);     // long run across many words (R2)
        run_req(1, 8, 1'b1);      // request while busy is ignored (R8)
        run_req(4095, 0, 1'b0);   // zero length at unaligned end (R7)
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule